// File: doc/BRIEF.md
# Signed Long-by-Word Divide Unit

This unit divides a signed double-width dividend by a signed single-width divisor, one quotient bit per clock. The dividend comes from a register pair: the even register supplies the upper word and the following register supplies the lower word. The unit works on the magnitudes of both operands and fixes the signs in a final cycle. It returns a quotient and a remainder, a write strobe for the register pair, and the four condition flags N, Z, V and C.

The write strobe rises only when the quotient fits in one word. When the divisor is zero, or the quotient does not fit, the register pair must stay as it is. In those cases only the flags report the error. The surrounding datapath reads the operands and decodes the instruction. It pulses `start` and waits for `done`. `W` sets the word width and defaults to 16.

Top module: `sdiv_pair`

## Requirements
- R1: The dividend is the signed 2W-bit value {`op_hi`, `op_lo`}, with `op_hi` in the upper half. The divisor is `op_div`, read as a signed W-bit value.
- R2: When the divisor is non-zero and the quotient fits in W bits, `wr_pair` pulses together with `done`. `quot` holds the quotient truncated toward zero. `rem` holds the remainder, which carries the sign of the dividend.
- R3: With a zero divisor, `done` sets V=1 and C=1, keeps N and Z at their previous values, and leaves `wr_pair` low.
- R4: When the true quotient is above 2^(W-1)-1 or below -2^(W-1), `done` sets V=1 and C=0. N shows the sign of the true quotient, Z=0, and `wr_pair` stays low.
- R5: On a successful divide, V=0 and C=0. N=1 exactly when the quotient is negative, and Z=1 exactly when it is zero.
- R6: A `start` seen while idle raises `busy` at the next edge. `done` is a single-cycle pulse at edge 2W+1 after the start edge, and `busy` falls at that same edge.
- R7: A `start`, or any change of operands, while `busy` is high is ignored. The running divide completes with its original operands.
- R8: Reset clears `busy`, `done`, `wr_pair` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a divide when idle |
| op_hi | input | W | upper dividend word (even register) |
| op_lo | input | W | lower dividend word (odd register) |
| op_div | input | W | signed divisor |
| busy | output | 1 | divide in progress |
| done | output | 1 | one-cycle completion pulse |
| wr_pair | output | 1 | write quotient and remainder to the pair |
| quot | output | W | quotient |
| rem | output | W | remainder |
| flag_n | output | 1 | negative |
| flag_z | output | 1 | zero |
| flag_v | output | 1 | overflow or divide by zero |
| flag_c | output | 1 | divide by zero |

## Verification
With W=4 the bench sweeps every dividend against every divisor, so all sign combinations and all overflow edges are covered. This includes the most negative dividend divided by -1, and quotients landing exactly on -2^(W-1) and 2^(W-1)-1. A design that handled these badly would have visible symptoms:
- Off-by-one overflow limits would flag a legal -8 quotient or write an out-of-range one.
- Floor rounding would give the remainder the divisor's sign.
- A zero divisor that fell into the normal path would write garbage to the pair, or clear N and Z.

Extra divides inject a second start partway through, which catches a unit that reloads while busy.

// File: rtl/sdiv_pair.sv
module sdiv_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_hi,
  input  logic [W-1:0] op_lo,
  input  logic [W-1:0] op_div,
  output logic         busy,
  output logic         done,
  output logic         wr_pair,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int CW = $clog2(2*W+1);
  localparam logic [2*W-1:0] LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [CW-1:0]  cnt;
  logic [2*W-1:0] acc;
  logic [W:0]     part;
  logic [W-1:0]   dmag;
  logic           sa, sb;

  wire [2*W-1:0] dvd     = {op_hi, op_lo};
  wire [2*W-1:0] dvd_mag = dvd[2*W-1] ? -dvd : dvd;
  wire [W-1:0]   div_mag = op_div[W-1] ? -op_div : op_div;
  wire [W:0]     trial   = {part[W-1:0], acc[2*W-1]};
  wire           fits    = trial >= {1'b0, dmag};
  wire           dz      = (dmag == '0);
  wire           qneg    = sa ^ sb;
  wire           ovf     = qneg ? (acc > LIM) : (acc >= LIM);
  wire           last    = busy && (cnt == '0);
  wire [W-1:0]   qmag    = acc[W-1:0];
  wire [W-1:0]   rmag    = part[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; wr_pair <= 1'b0;
      cnt <= '0; acc <= '0; part <= '0; dmag <= '0; sa <= 1'b0; sb <= 1'b0;
      quot <= '0; rem <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0; flag_c <= 1'b0;
    end else begin
      done    <= 1'b0;
      wr_pair <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= CW'(2*W);
          acc  <= dvd_mag;
          part <= '0;
          dmag <= div_mag;
          sa   <= op_hi[W-1];
          sb   <= op_div[W-1];
        end
      end else if (cnt != '0) begin
        part <= fits ? trial - {1'b0, dmag} : trial;
        acc  <= {acc[2*W-2:0], fits};
        cnt  <= cnt - 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (dz) begin
          flag_v <= 1'b1;
          flag_c <= 1'b1;
        end else begin
          flag_c <= 1'b0;
          flag_n <= qneg && (acc != '0);
          flag_z <= (acc == '0);
          if (ovf) begin
            flag_v <= 1'b1;
          end else begin
            flag_v  <= 1'b0;
            wr_pair <= 1'b1;
            quot    <= qneg ? -qmag : qmag;
            rem     <= sa ? -rmag : rmag;
          end
        end
      end
    end
  end

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_write_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pair |-> (done && !flag_v && !flag_c));
  p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && dz) |=> (done && flag_v && flag_c && !wr_pair));
  p_no_ovf_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !dz && ovf) |=> (done && flag_v && !flag_c && !wr_pair));
  p_hold_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dmag) && $stable(sa) && $stable(sb)));
endmodule

// File: tb/sim_sdiv_pair.sv
module sim_sdiv_pair;
  localparam int W = 4;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_hi = '0, op_lo = '0, op_div = '0;
  logic busy, done, wr_pair, flag_n, flag_z, flag_v, flag_c;
  logic [W-1:0] quot, rem;
  int checks = 0, fails = 0;
  logic pn = 1'b0, pz = 1'b0;

  always #(P/2) clk = ~clk;

  sdiv_pair #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_hi(op_hi), .op_lo(op_lo),
    .op_div(op_div), .busy(busy), .done(done), .wr_pair(wr_pair), .quot(quot),
    .rem(rem), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [W-1:0] h, input logic [W-1:0] l,
                       input logic [W-1:0] d, input bit intrude);
    int a, b, q, r;
    bit ew, en, ez, ev, ec;
    string req;
    a = int'($signed({h, l}));
    b = int'($signed(d));
    q = 0; r = 0;
    if (b == 0) begin
      req = "R3"; ew = 0; ev = 1; ec = 1; en = pn; ez = pz;
    end else begin
      q = a / b; r = a % b;
      ec = 0; en = (q < 0); ez = (q == 0);
      if (q > (1 << (W-1)) - 1 || q < -(1 << (W-1))) begin
        req = "R4"; ew = 0; ev = 1;
      end else begin
        req = "R2/R5"; ew = 1; ev = 0;
      end
    end
    @(negedge clk);
    op_hi = h; op_lo = l; op_div = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6", $sformatf("busy=%b", busy), "busy=1");
    if (intrude) begin
      @(negedge clk);
      op_hi = ~h; op_lo = l ^ 4'h5; op_div = d + 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2*W-2) @(negedge clk);
    end else begin
      repeat (2*W) @(negedge clk);
    end
    chk(done === 1'b0 && busy === 1'b1, "R6",
        $sformatf("done=%b busy=%b", done, busy), "done=0 busy=1");
    @(negedge clk);
    if (intrude) req = {req, " R7"};
    chk(done === 1'b1 && busy === 1'b0, {"R6 ", req},
        $sformatf("done=%b busy=%b", done, busy), "done=1 busy=0");
    chk(wr_pair === ew && flag_n === en && flag_z === ez && flag_v === ev && flag_c === ec &&
        (!ew || (quot === W'(q) && rem === W'(r))),
        {"R1 ", req},
        $sformatf("a=%0d b=%0d wr=%b nzvc=%b%b%b%b q=%0d r=%0d", a, b, wr_pair,
                  flag_n, flag_z, flag_v, flag_c, $signed(quot), $signed(rem)),
        $sformatf("wr=%b nzvc=%b%b%b%b q=%0d r=%0d", ew, en, ez, ev, ec, q, r));
    pn = en; pz = ez;
    @(negedge clk);
    chk(done === 1'b0 && wr_pair === 1'b0, "R6",
        $sformatf("done=%b wr=%b", done, wr_pair), "done=0 wr=0");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, wr_pair, flag_n, flag_z, flag_v, flag_c} === 7'b0, "R8",
        $sformatf("%b", {busy, done, wr_pair, flag_n, flag_z, flag_v, flag_c}), "0000000");
    rst_n = 1'b1;
    // directed edges: most negative / -1, exact limits, zero divisor after non-zero flags
    do_op(4'h8, 4'h0, 4'hF, 1'b0);
    do_op(4'hF, 4'hC, 4'hF, 1'b0);
    do_op(4'h0, 4'h7, 4'h1, 1'b0);
    do_op(4'hF, 4'hF, 4'h0, 1'b0);
    do_op(4'h0, 4'h0, 4'h3, 1'b0);
    // R7: intruding start while busy
    do_op(4'hF, 4'hB, 4'h3, 1'b1);
    do_op(4'h0, 4'h9, 4'hE, 1'b1);
    // exhaustive sweep
    for (int i = 0; i < (1 << (2*W)); i++)
      for (int j = 0; j < (1 << W); j++)
        do_op(i[2*W-1:W], i[W-1:0], j[W-1:0], 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule